// File: doc/BRIEF.md
# Charge-Transfer Burst Pulse Generator

This block produces the repeating pulse train that drives the charge-transfer phases of a capacitive touch-sensing front end. Each pulse is a high phase followed by a low phase. Both phase lengths are counted in pulse-clock cycles, and the pulse clock is the system clock divided by a power of two. An optional spread-spectrum ramp adds extra cycles to each high phase, so that the pulse train does not sit on one fixed frequency.

The configuration inputs are sampled on the cycle in which `run_i` starts an idle block. While the block runs it ignores any change on them. A prescaler and low-phase combination that leaves too little settling time is refused: the block raises a configuration-error flag and produces no pulses until `run_i` is removed. A one-cycle strobe marks the last system-clock cycle of every complete pulse. Pulse counting, the analog switches and any register access belong to the surrounding logic.

Top module: `ct_pulse_gen`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first run, `pulse_o`, `eop_o` and `cfg_err_o` are 0.
- R2: The pulse clock is the system clock divided by 2^`psc_i` (code 0..7). Every phase lasts a whole number of pulse-clock periods.
- R3: The high phase lasts (`hi_len_i`+1+J)·2^P system cycles, where J is the current jitter (0 when spread spectrum is off). `pulse_o` rises on the cycle after the edge that starts the run.
- R4: The low phase lasts (`lo_len_i`+1)·2^P system cycles, and `pulse_o` is 0 throughout it.
- R5: The combination is illegal when P=0 with `lo_len_i`<2, or when P=1 with `lo_len_i`<1. Every other combination is legal. Starting with an illegal combination sets `cfg_err_o` from the next cycle until `run_i` falls, and no pulse is produced.
- R6: `eop_o` is high for exactly the last system cycle of each low phase. The next high phase follows with no gap.
- R7: With `ss_en_i`=1 and `ss_psc_i`=0, J takes the values 0,1,…,`ss_dev_i`,0,… and advances by one after each pulse.
- R8: With `ss_en_i`=1 and `ss_psc_i`=1, J advances by one after every second pulse. After n pulses, J = floor(n/2) mod (`ss_dev_i`+1).
- R9: When `run_i` falls, `pulse_o` and `eop_o` are 0 by the next sampling point. The phase, prescaler and jitter state are cleared, so a new run starts with a full high phase and J=0.
- R10: Changes on `psc_i`, `hi_len_i`, `lo_len_i` and the spread-spectrum inputs during a run have no effect on the outputs.
- R11: With `ss_en_i`=0, J is 0 whatever value `ss_dev_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start and keep running the pulse train |
| psc_i | input | 3 | Pulse-clock divide code P (÷2^P) |
| hi_len_i | input | 4 | High phase length minus one, in pulse-clock cycles |
| lo_len_i | input | 4 | Low phase length minus one, in pulse-clock cycles |
| ss_en_i | input | 1 | Spread-spectrum enable |
| ss_dev_i | input | 7 | Maximum jitter, in pulse-clock cycles |
| ss_psc_i | input | 1 | Jitter step rate: 0 every pulse, 1 every second pulse |
| pulse_o | output | 1 | Charge-transfer pulse level |
| eop_o | output | 1 | Strobe on the last cycle of each pulse |
| cfg_err_o | output | 1 | Illegal prescaler and low-length combination |

## Verification
The assertions assume that `rst_ni` is released synchronously. They also assume that the configuration seen on a start edge is the configuration the block captured. The bench drives every input shortly after a falling clock edge, so all inputs are stable across each rising edge. The bench keeps `run_i` low long enough between runs for the block to go back to idle before a new configuration is applied. Configuration changes during a run are made on purpose, to show that the captured values win.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HIGH  = 2'd1,
    ST_LOW   = 2'd2,
    ST_FAULT = 2'd3
  } ctp_state_e;

  // Minimum low phase depends on the divide code (R5)
  function automatic logic lo_len_legal(input int unsigned psc, input int unsigned lo);
    if (psc == 0)      return lo >= 2;
    else if (psc == 1) return lo >= 1;
    else               return 1'b1;
  endfunction

endpackage

// File: rtl/ctp_prescaler.sv
module ctp_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(psc_i));
  end

  assign tick_o = (div_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ctp_jitter.sv
module ctp_jitter #(
  parameter int DEV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             step_psc_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic             adv_i,
  output logic [DEV_W-1:0] jit_o
);
  logic [DEV_W-1:0] jit_q;
  logic             half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jit_q  <= '0;
      half_q <= 1'b0;
    end else if (clr_i || !en_i) begin
      jit_q  <= '0;
      half_q <= 1'b0;
    end else if (adv_i) begin
      half_q <= ~half_q;
      if (!step_psc_i || half_q)
        jit_q <= (jit_q >= dev_i) ? '0 : jit_q + 1'b1;
    end
  end

  assign jit_o = en_i ? jit_q : '0;
endmodule

// File: rtl/ct_pulse_gen.sv
module ct_pulse_gen #(
  parameter int PSC_W = 3,
  parameter int LEN_W = 4,
  parameter int DEV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [LEN_W-1:0] hi_len_i,
  input  logic [LEN_W-1:0] lo_len_i,
  input  logic             ss_en_i,
  input  logic [DEV_W-1:0] ss_dev_i,
  input  logic             ss_psc_i,
  output logic             pulse_o,
  output logic             eop_o,
  output logic             cfg_err_o
);
  import ctp_pkg::*;

  localparam int PH_W = $clog2((1 << LEN_W) + (1 << DEV_W) + 1);

  ctp_state_e       state_q;
  logic [PSC_W-1:0] psc_q;
  logic [LEN_W-1:0] hi_q, lo_q;
  logic             ss_en_q, ss_psc_q;
  logic [DEV_W-1:0] dev_q;
  logic [PH_W-1:0]  ph_q;
  logic [PH_W-1:0]  cur_len;
  logic [DEV_W-1:0] jit;
  logic             active, tick, phase_done, start_ok;

  assign active   = run_i && (state_q == ST_HIGH || state_q == ST_LOW);
  assign start_ok = lo_len_legal(int'(psc_i), int'(lo_len_i));

  ctp_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!active),
    .psc_i (psc_q),
    .tick_o(tick)
  );

  always_comb begin
    if (state_q == ST_HIGH)
      cur_len = PH_W'(hi_q) + PH_W'(jit) + PH_W'(1);
    else
      cur_len = PH_W'(lo_q) + PH_W'(1);
  end

  assign phase_done = active && tick && (ph_q == cur_len - PH_W'(1));

  ctp_jitter #(.DEV_W(DEV_W)) u_jit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!active),
    .en_i      (ss_en_q),
    .step_psc_i(ss_psc_q),
    .dev_i     (dev_q),
    .adv_i     (eop_o),
    .jit_o     (jit)
  );

  // Configuration capture on start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q    <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      ss_en_q  <= 1'b0;
      ss_psc_q <= 1'b0;
      dev_q    <= '0;
    end else if (state_q == ST_IDLE && run_i) begin
      psc_q    <= psc_i;
      hi_q     <= hi_len_i;
      lo_q     <= lo_len_i;
      ss_en_q  <= ss_en_i;
      ss_psc_q <= ss_psc_i;
      dev_q    <= ss_dev_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          ph_q <= '0;
          if (run_i) state_q <= start_ok ? ST_HIGH : ST_FAULT;
        end
        ST_FAULT: if (!run_i) state_q <= ST_IDLE;
        default: begin
          if (!run_i) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
          end else if (phase_done) begin
            state_q <= (state_q == ST_HIGH) ? ST_LOW : ST_HIGH;
            ph_q    <= '0;
          end else if (tick) begin
            ph_q <= ph_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign pulse_o   = run_i && (state_q == ST_HIGH);
  assign eop_o     = (state_q == ST_LOW) && phase_done;
  assign cfg_err_o = (state_q == ST_FAULT);

endmodule

// File: rtl/ct_pulse_gen_chk.sv
module ct_pulse_gen_chk #(
  parameter int PSC_W = 3,
  parameter int LEN_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [PSC_W-1:0] psc_i,
  input logic [LEN_W-1:0] lo_len_i,
  input logic             pulse_o,
  input logic             eop_o,
  input logic             cfg_err_o
);
  import ctp_pkg::*;

  p_err_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!pulse_o && !eop_o));

  p_err_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> !lo_len_legal(int'($past(psc_i)), int'($past(lo_len_i))));

  p_eop_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !eop_o);

  p_eop_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> !pulse_o);

  p_next_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> (pulse_o || !run_i));

  p_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!pulse_o && !eop_o));

endmodule

bind ct_pulse_gen ct_pulse_gen_chk #(.PSC_W(PSC_W), .LEN_W(LEN_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_i),
  .psc_i    (psc_i),
  .lo_len_i (lo_len_i),
  .pulse_o  (pulse_o),
  .eop_o    (eop_o),
  .cfg_err_o(cfg_err_o)
);

// File: tb/ct_pulse_gen_tb.sv
`timescale 1ns/1ps
module ct_pulse_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [2:0] psc = '0;
  logic [3:0] hi_len = '0, lo_len = '0;
  logic       ss_en = 1'b0, ss_psc = 1'b0;
  logic [6:0] ss_dev = '0;
  logic       pulse, eop, cfg_err;

  int    n_cmp = 0, n_bad = 0, cycles = 0;
  bit    done = 0;
  string tag = "R1";

  // Model state: 0 idle, 1 high, 2 low, 3 fault
  int m_st = 0, m_rem = 0, m_p = 0, m_hi = 0, m_lo = 0, m_dev = 0, m_pulses = 0;
  bit m_ss = 0, m_sp = 0;

  always #2 clk = ~clk;

  ct_pulse_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .psc_i(psc),
    .hi_len_i(hi_len), .lo_len_i(lo_len), .ss_en_i(ss_en),
    .ss_dev_i(ss_dev), .ss_psc_i(ss_psc),
    .pulse_o(pulse), .eop_o(eop), .cfg_err_o(cfg_err)
  );

  function automatic int jit_now();
    if (!m_ss) return 0;
    return (m_pulses >> m_sp) % (m_dev + 1);
  endfunction

  function automatic bit legal(int p, int lo);
    if (p == 0) return lo >= 3 - 1;
    if (p == 1) return lo >= 1;
    return 1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) m_st = 0;
    else case (m_st)
      0: if (run) begin
        if (legal(psc, lo_len)) begin
          m_p = psc; m_hi = hi_len; m_lo = lo_len;
          m_ss = ss_en; m_sp = ss_psc; m_dev = ss_dev; m_pulses = 0;
          m_st = 1; m_rem = (m_hi + 1) << m_p;
        end else m_st = 3;
      end
      3: if (!run) m_st = 0;
      1: if (!run) m_st = 0;
         else if (m_rem == 1) begin m_st = 2; m_rem = (m_lo + 1) << m_p; end
         else m_rem--;
      default: if (!run) m_st = 0;
         else if (m_rem == 1) begin
           m_pulses++;
           m_st = 1; m_rem = (m_hi + 1 + jit_now()) << m_p;
         end else m_rem--;
    endcase
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cmp("pulse_o", pulse, (run && m_st == 1) ? 1 : 0);
    cmp("eop_o", eop, (run && m_st == 2 && m_rem == 1) ? 1 : 0);
    cmp("cfg_err_o", cfg_err, (m_st == 3) ? 1 : 0);
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 60000 && !done) begin
    n_bad++;
    $display("FAIL watchdog act=%0d exp=0", cycles);
    finish_run();
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic start(string t, int p, int h, int l, bit se, int d, bit sp, int n);
    run = 0;
    step(3);
    tag = t; psc = 3'(p); hi_len = 4'(h); lo_len = 4'(l);
    ss_en = se; ss_dev = 7'(d); ss_psc = sp;
    run = 1;
    step(n);
  endtask

  initial begin
    step(2);
    // R1: outputs low during reset
    cmp("pulse_o", pulse, 0);
    cmp("eop_o", eop, 0);
    cmp("cfg_err_o", cfg_err, 0);
    rst_n = 1;
    step(4);                                        // R1 idle after reset
    start("R2", 0, 0, 2, 0, 0, 0, 40);              // fastest legal, P=0 lo=3 cycles
    start("R3", 1, 3, 1, 0, 0, 0, 80);              // R3/R4 at P=1
    start("R4", 3, 2, 0, 0, 0, 0, 160);             // P=3, low of 1 pulse cycle
    start("R2", 7, 0, 0, 0, 0, 0, 600);             // divide by 128
    start("R5", 0, 4, 1, 0, 0, 0, 20);              // illegal: P=0 lo<2
    start("R5", 1, 4, 0, 0, 0, 0, 20);              // illegal: P=1 lo<1
    start("R5", 2, 0, 0, 0, 0, 0, 40);              // legal boundary P=2 lo=0
    start("R6", 0, 1, 3, 0, 0, 0, 60);              // back-to-back pulses
    start("R7", 0, 0, 2, 1, 3, 0, 200);             // ramp every pulse
    start("R8", 0, 0, 2, 1, 2, 1, 200);             // ramp every second pulse
    start("R11", 1, 1, 1, 0, 5, 0, 100);            // deviation ignored when disabled
    start("R10", 1, 1, 1, 1, 1, 0, 20);
    psc = 0; hi_len = 9; lo_len = 0; ss_en = 0; ss_dev = 7; ss_psc = 1; // R10 ignored mid-run
    step(80);
    start("R9", 2, 5, 2, 1, 4, 0, 7);               // stop mid high phase
    tag = "R9"; run = 0;
    step(1);
    cmp("pulse_o", pulse, 0);                       // R9 low after stop
    step(2);
    run = 1;                                        // R9 restart from a clean state
    step(150);
    run = 0;
    step(5);
    finish_run();
  end
endmodule